// File: doc/BRIEF.md
# Host Register Bus Interface (Intel / Motorola, multiplexed or separate address)

This block connects an 8-bit host processor bus to the register space of a larger device. The same pins serve two protocol families. In the Intel style, reads and writes have separate active-low strobes. In the Motorola style, one pin gives the transfer direction and an active-low data strobe frames the access. The register address is 7 bits wide. It comes either from dedicated address pins or, on a multiplexed bus, from the shared data lines, captured when the address-latch input falls.

The protocol is chosen by the level on the address-latch pin. If the pin stays low, the block runs Intel with separate address pins. If it stays high, the block runs Motorola. If the pin pulses, the block switches to Intel multiplexed operation at the first falling edge and stays there until reset. All host controls pass through two-stage synchronizers. Each access then becomes one internal write pulse or one end-of-read pulse. A small demonstration bank sits behind these pulses: a storage register, an accumulating register and a clear-on-read interrupt register. The bank drives an open-drain interrupt request.

Top module: `hostbus_if`

## Requirements
- R1: While `rst` is high and right after it falls, the storage, accumulator and interrupt registers hold 0x00, `irq_pull` is 0, `ad_oe` is 0 and `ad_out` is 0x00.
- R2: With `ale` held low (Intel, separate address), a low pulse on `wr_rw_n` while `cs_n` is low writes `ad_in` to the register selected by `addr`. A later low pulse on `rd_ds_n` returns that register on `ad_out`. Address 0 is the storage register: it reads back the last value written.
- R3: While `cs_n` is high, no strobe writes anything and `ad_oe` stays 0. `ad_oe` is 1 only while `cs_n` is low and a read is active. A read is active when `rd_ds_n` is low in Intel mode, or when `rd_ds_n` is low with `wr_rw_n` high in Motorola mode.
- R4: When `ale` pulses, the value on `ad_in[6:0]` at its falling edge becomes the register address for later accesses, and `addr` is ignored. This multiplexed mode holds until reset.
- R5: With `ale` held high (Motorola), `wr_rw_n`=0 selects a write and `wr_rw_n`=1 selects a read. A write takes effect when `rd_ds_n` rises.
- R6: Each write access commits exactly once, on its trailing strobe edge, however long the strobe is held. Address 1 is an accumulator: each write adds the written value to it, modulo 256.
- R7: A write to address 2 ORs the data into a pending-interrupt register. `irq_pull` is 1 while that register is non-zero. A read of address 2 returns the register and clears it once the read ends.
- R8: Reads of addresses 3 to 127 return 0x00. Writes to those addresses change no register.
- R9: Raising `rst` during operation returns every register and the bus mode to their reset state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_ds_n | input | 1 | Intel read strobe / Motorola data strobe, active low |
| wr_rw_n | input | 1 | Intel write strobe (active low) / Motorola direction (1 = read, 0 = write) |
| ale | input | 1 | Address latch; its static level also selects the protocol |
| addr | input | 7 | Separate register address pins |
| ad_in | input | 8 | Data from the host; address on a multiplexed bus |
| ad_out | output | 8 | Read data toward the host |
| ad_oe | output | 1 | Output enable for `ad_out` |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
The assertions assume that the host keeps `addr` and `ad_in` stable from the start of each strobe until at least four clocks after its trailing edge. They also assume that the multiplexed address stays on `ad_in` for several clocks after `ale` falls, since the synchronized control path lags the pins by up to three clocks. They further assume that `ale` is steady during accesses and that the direction pin does not change while the data strobe is low. Every bench task holds strobes for at least four clocks, keeps address and data unchanged for six clocks after release, and changes mode only through reset or an `ale` pulse while the bus is idle.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
    typedef enum logic [1:0] {
        MODE_I_DEMUX = 2'd0,
        MODE_I_MUX   = 2'd1,
        MODE_MOTO    = 2'd2
    } bus_mode_e;

    localparam int ADDR_STORE = 0;
    localparam int ADDR_ACCUM = 1;
    localparam int ADDR_IRQ   = 2;
endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/hostbus_decode.sv
module hostbus_decode
    import hostbus_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n_s,
    input  logic          rd_n_s,
    input  logic          wr_n_s,
    input  logic          ale_s,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] ad_in,
    output bus_mode_e     mode,
    output logic          wr_pulse,
    output logic          rd_done,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] rd_addr
);
    typedef struct packed {
        logic          ale;
        logic          mux_seen;
        logic [AW-1:0] lat;
        logic          wr_act;
        logic          rd_act;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          wr_pulse;
        logic          rd_done;
    } dec_t;

    dec_t          st_d, st_q;
    logic          sel, wr_act, rd_act;
    logic [AW-1:0] cur_addr;

    always_comb begin
        if (st_q.mux_seen)  mode = MODE_I_MUX;
        else if (ale_s)     mode = MODE_MOTO;
        else                mode = MODE_I_DEMUX;

        sel = !cs_n_s;
        if (mode == MODE_MOTO) begin
            wr_act = sel && !rd_n_s && !wr_n_s;
            rd_act = sel && !rd_n_s &&  wr_n_s;
        end else begin
            wr_act = sel && !wr_n_s;
            rd_act = sel && !rd_n_s;
        end
        cur_addr = (mode == MODE_I_MUX) ? st_q.lat : addr;

        st_d     = st_q;
        st_d.ale = ale_s;
        if (st_q.ale && !ale_s) begin
            st_d.mux_seen = 1'b1;
            st_d.lat      = ad_in[AW-1:0];
        end
        if (wr_act || rd_act) st_d.addr = cur_addr;
        if (wr_act)           st_d.data = ad_in;
        st_d.wr_act   = wr_act;
        st_d.rd_act   = rd_act;
        st_d.wr_pulse = st_q.wr_act && !wr_act;
        st_d.rd_done  = st_q.rd_act && !rd_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_pulse = st_q.wr_pulse;
    assign rd_done  = st_q.rd_done;
    assign acc_addr = st_q.addr;
    assign wr_data  = st_q.data;
    assign rd_addr  = cur_addr;

    // R6
    one_commit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);

    // R3
    wr_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(!cs_n_s, 2));

    // R4
    mux_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ale && !ale_s) |=> (rd_addr == $past(ad_in[AW-1:0])));
endmodule

// File: rtl/hostbus_regbank.sv
module hostbus_regbank
    import hostbus_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_pulse,
    input  logic          rd_done,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq_pull
);
    localparam logic [AW-1:0] A_STORE = AW'(ADDR_STORE);
    localparam logic [AW-1:0] A_ACCUM = AW'(ADDR_ACCUM);
    localparam logic [AW-1:0] A_IRQ   = AW'(ADDR_IRQ);

    typedef struct packed {
        logic [DW-1:0] store;
        logic [DW-1:0] accum;
        logic [DW-1:0] pend;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_done && acc_addr == A_IRQ) st_d.pend = '0;
        if (wr_pulse) begin
            case (acc_addr)
                A_STORE: st_d.store = wr_data;
                A_ACCUM: st_d.accum = st_q.accum + wr_data;
                A_IRQ:   st_d.pend  = st_d.pend | wr_data;
                default: ;
            endcase
        end
        case (rd_addr)
            A_STORE: rd_data = st_q.store;
            A_ACCUM: rd_data = st_q.accum;
            A_IRQ:   rd_data = st_q.pend;
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_pull = |st_q.pend;

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && acc_addr == A_IRQ && wr_data != '0) |=> irq_pull);

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !wr_pulse && acc_addr == A_IRQ) |=> !irq_pull);

    // R8
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && acc_addr > A_IRQ) |=> ($stable(st_q.store) && $stable(st_q.accum)));
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
    import hostbus_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_ds_n,
    input  logic          wr_rw_n,
    input  logic          ale,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          irq_pull
);
    localparam int NCTL = 4;

    logic [NCTL-1:0] ctl_s;
    bus_mode_e       mode;
    logic            wr_pulse, rd_done;
    logic [AW-1:0]   acc_addr, rd_addr;
    logic [DW-1:0]   wr_data, rd_data;

    hostbus_sync #(.W(NCTL), .RST_VAL(4'b1110)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, rd_ds_n, wr_rw_n, ale}),
        .q   (ctl_s)
    );

    hostbus_decode #(.AW(AW), .DW(DW)) dec_i (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (ctl_s[3]),
        .rd_n_s   (ctl_s[2]),
        .wr_n_s   (ctl_s[1]),
        .ale_s    (ctl_s[0]),
        .addr     (addr),
        .ad_in    (ad_in),
        .mode     (mode),
        .wr_pulse (wr_pulse),
        .rd_done  (rd_done),
        .acc_addr (acc_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr)
    );

    hostbus_regbank #(.AW(AW), .DW(DW)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_pulse (wr_pulse),
        .rd_done  (rd_done),
        .acc_addr (acc_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq_pull (irq_pull)
    );

    always_comb begin
        if (rst)                    ad_oe = 1'b0;
        else if (mode == MODE_MOTO) ad_oe = !cs_n && !rd_ds_n && wr_rw_n;
        else                        ad_oe = !cs_n && !rd_ds_n;
        ad_out = ad_oe ? rd_data : '0;
    end

    // R3
    oe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> !cs_n);
endmodule

// File: tb/hostbus_if_tb.sv
module hostbus_if_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_ds_n = 1'b1, wr_rw_n = 1'b1, ale = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe, irq_pull;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    hostbus_if dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_rw_n(wr_rw_n),
        .ale(ale), .addr(addr), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .irq_pull(irq_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic ale_lvl);
        ale = ale_lvl;
        rst = 1'b1;
        wait_n(4);
        rst = 1'b0;
        wait_n(4);
    endtask

    task automatic i_wr(input logic [6:0] a, input logic [7:0] d, input int hold, input logic use_cs);
        addr = a; ad_in = d;
        @(negedge clk);
        cs_n = !use_cs; wr_rw_n = 1'b0;
        wait_n(hold);
        wr_rw_n = 1'b1; cs_n = 1'b1;
        wait_n(6);
    endtask

    task automatic i_rd(input logic [6:0] a, output logic [7:0] d, output logic oe);
        addr = a;
        @(negedge clk);
        cs_n = 1'b0; rd_ds_n = 1'b0;
        wait_n(4);
        d = ad_out; oe = ad_oe;
        rd_ds_n = 1'b1; cs_n = 1'b1;
        wait_n(6);
    endtask

    task automatic m_wr(input logic [6:0] a, input logic [7:0] d);
        addr = a; ad_in = d; wr_rw_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b0; rd_ds_n = 1'b0;
        wait_n(4);
        rd_ds_n = 1'b1; cs_n = 1'b1;
        wait_n(6);
        wr_rw_n = 1'b1;
    endtask

    task automatic m_rd(input logic [6:0] a, output logic [7:0] d, output logic oe);
        addr = a; wr_rw_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0; rd_ds_n = 1'b0;
        wait_n(4);
        d = ad_out; oe = ad_oe;
        rd_ds_n = 1'b1; cs_n = 1'b1;
        wait_n(6);
    endtask

    task automatic latch_addr(input logic [6:0] a);
        ad_in = {1'b0, a};
        @(negedge clk);
        ale = 1'b1;
        wait_n(3);
        ale = 1'b0;
        wait_n(6);
    endtask

    task automatic t_reset_state();
        logic [7:0] d; logic oe;
        rst = 1'b1;
        wait_n(3);
        chk("R1 irq in reset", irq_pull, 0);
        chk("R1 oe in reset", ad_oe, 0);
        chk("R1 data in reset", ad_out, 0);
        rst = 1'b0;
        wait_n(4);
        i_rd(7'd0, d, oe); chk("R1 store reset", d, 8'h00);
        i_rd(7'd1, d, oe); chk("R1 accum reset", d, 8'h00);
        i_rd(7'd2, d, oe); chk("R1 pend reset", d, 8'h00);
    endtask

    task automatic t_demux();
        logic [7:0] d; logic oe;
        i_wr(7'd0, 8'hA5, 4, 1'b1);
        i_rd(7'd0, d, oe);
        chk("R2 store readback", d, 8'hA5);
        chk("R3 oe during read", oe, 1);
        i_wr(7'd0, 8'h3C, 5, 1'b1);
        i_rd(7'd0, d, oe);
        chk("R2 store overwrite", d, 8'h3C);
    endtask

    task automatic t_cs_gate();
        logic [7:0] d; logic oe;
        i_wr(7'd0, 8'hFF, 4, 1'b0);
        i_rd(7'd0, d, oe);
        chk("R3 write ignored with cs high", d, 8'h3C);
        addr = 7'd0;
        @(negedge clk);
        rd_ds_n = 1'b0;
        wait_n(4);
        chk("R3 no oe with cs high", ad_oe, 0);
        rd_ds_n = 1'b1;
        cs_n = 1'b0; wr_rw_n = 1'b0; ad_in = 8'h3C;
        wait_n(4);
        chk("R3 no oe during write", ad_oe, 0);
        wr_rw_n = 1'b1; cs_n = 1'b1;
        wait_n(6);
    endtask

    task automatic t_once();
        logic [7:0] d; logic oe;
        i_wr(7'd1, 8'h05, 40, 1'b1);
        i_rd(7'd1, d, oe);
        chk("R6 long strobe commits once", d, 8'h05);
        i_wr(7'd1, 8'hFE, 4, 1'b1);
        i_rd(7'd1, d, oe);
        chk("R6 accumulate wraps", d, 8'h03);
    endtask

    task automatic t_unmapped();
        logic [7:0] d; logic oe;
        i_wr(7'd9, 8'h77, 4, 1'b1);
        i_wr(7'd127, 8'h11, 4, 1'b1);
        i_rd(7'd9, d, oe);   chk("R8 unmapped reads zero", d, 8'h00);
        i_rd(7'd0, d, oe);   chk("R8 store untouched", d, 8'h3C);
        i_rd(7'd1, d, oe);   chk("R8 accum untouched", d, 8'h03);
        i_rd(7'd2, d, oe);   chk("R8 pend untouched", d, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d; logic oe;
        chk("R7 irq idle", irq_pull, 0);
        i_wr(7'd2, 8'h05, 4, 1'b1);
        chk("R7 irq raised", irq_pull, 1);
        i_wr(7'd2, 8'h40, 4, 1'b1);
        i_rd(7'd2, d, oe);
        chk("R7 pending ORed", d, 8'h45);
        chk("R7 irq cleared by read", irq_pull, 0);
        i_rd(7'd2, d, oe);
        chk("R7 pending zero after read", d, 8'h00);
    endtask

    task automatic t_mux();
        logic [7:0] d; logic oe;
        latch_addr(7'd0);
        i_wr(7'd1, 8'h6B, 4, 1'b1);
        latch_addr(7'd0);
        i_rd(7'd1, d, oe);
        chk("R4 mux write to latched addr", d, 8'h6B);
        latch_addr(7'd1);
        i_rd(7'd0, d, oe);
        chk("R4 mux read latched accum", d, 8'h03);
        i_rd(7'd0, d, oe);
        chk("R4 latch persists", d, 8'h03);
    endtask

    task automatic t_moto();
        logic [7:0] d; logic oe;
        do_reset(1'b1);
        m_wr(7'd0, 8'h92);
        m_rd(7'd0, d, oe);
        chk("R5 moto write/read", d, 8'h92);
        chk("R5 moto oe on read", oe, 1);
        m_wr(7'd1, 8'h10);
        m_wr(7'd1, 8'h01);
        m_rd(7'd1, d, oe);
        chk("R5 moto accum", d, 8'h11);
        addr = 7'd0; wr_rw_n = 1'b0; ad_in = 8'h92;
        @(negedge clk);
        cs_n = 1'b0; rd_ds_n = 1'b0;
        wait_n(4);
        chk("R3 moto no oe on write", ad_oe, 0);
        rd_ds_n = 1'b1; cs_n = 1'b1;
        wait_n(6);
        wr_rw_n = 1'b1;
    endtask

    task automatic t_reset_mid();
        logic [7:0] d; logic oe;
        m_wr(7'd2, 8'h01);
        chk("R9 irq before reset", irq_pull, 1);
        do_reset(1'b1);
        chk("R9 irq after reset", irq_pull, 0);
        m_rd(7'd0, d, oe);
        chk("R9 store after reset", d, 8'h00);
        m_rd(7'd1, d, oe);
        chk("R9 accum after reset", d, 8'h00);
    endtask

    initial begin
        t_reset_state();
        t_demux();
        t_cs_gate();
        t_once();
        t_unmapped();
        t_irq();
        t_mux();
        t_moto();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule